// File: doc/BRIEF.md
# Saturating Floating-Point Result Rounder

This block is the final rounding stage of a vector floating-point unit. It receives an unrounded result as a sign bit, a biased exponent and a fraction, together with the guard and sticky bits from the arithmetic stage. It also receives the two-bit rounding-mode field and the inexact-exception-enable bit from the status and control register. It returns the rounded result one clock later. The parameter `DOUBLE` selects the 11-bit exponent and 52-bit fraction format. Its default is the 8-bit exponent and 23-bit fraction format.

The block rounds only in round-to-nearest mode, and only while inexact exceptions are disabled. Ties go to even. If rounding carries out of the mantissa, the exponent is incremented. If the exponent is already at or above the largest finite exponent, the result saturates to the largest finite magnitude instead of becoming infinity. For the three directed modes, the block returns the truncated input unchanged.

The block also flags an input that is denormal. It builds two masks for the status register, one to OR in and one to AND out. Both are placed in the lower lane, or moved up by 15 bit positions for the upper lane.

Top module: `fp_sat_rounder`

## Requirements
- R1: When `inexact_en` is 1, the output sign, exponent and fraction equal the input, whatever the mode, guard and sticky bits are.
- R2: With `rnd_mode` 2'b00 (nearest) and `inexact_en` 0, the fraction is incremented only when guard is 1 and either sticky is 1 or fraction bit 0 is 1, so an exact tie rounds to even.
- R3: When the increment carries out of the fraction and the input exponent is below 254 (2046 for double), the output exponent is the input exponent plus one and the output fraction is zero.
- R4: When the increment carries out and the input exponent is 254 or more (2046 or more for double), the output keeps the sign, takes exponent 254 (2046) and an all-ones fraction, and `out_sat` is 1.
- R5: Modes 2'b01 (toward zero), 2'b10 and 2'b11 (toward an infinity) return the input unchanged, and `out_rounded` is 0.
- R6: `out_denorm` is 1 exactly when the input exponent is zero and the input fraction is non-zero.
- R7: `set_mask` holds `flag_in` in bits 14:0 when `lane_upper` is 0, and in bits 29:15 when it is 1. All other bits are zero.
- R8: `clr_mask` holds the guard flag at bit 1 and the inexact flag at bit 0 for the lower lane (32'h0000_0003), and the same pair moved up by 15 for the upper lane (32'h0001_8000).
- R9: All outputs are registered. `out_valid` equals `in_valid` from one cycle earlier. While `rst_n` is low, every output is zero.
- R10: When `in_valid` is 0, all data outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operand valid |
| in_sign | input | 1 | Input sign |
| in_exp | input | EXP_W | Input biased exponent |
| in_frac | input | FRAC_W | Input fraction |
| in_guard | input | 1 | Guard bit |
| in_sticky | input | 1 | Sticky bit |
| rnd_mode | input | 2 | Rounding mode: 00 nearest, 01 zero, 10/11 infinities |
| inexact_en | input | 1 | Inexact exception enable (1 disables rounding) |
| lane_upper | input | 1 | 1 selects the upper lane for the masks |
| flag_in | input | 15 | Exception flags for the lane |
| out_valid | output | 1 | Output valid |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_frac | output | FRAC_W | Result fraction |
| out_denorm | output | 1 | Input was denormal |
| out_rounded | output | 1 | Fraction was incremented |
| out_sat | output | 1 | Result saturated to largest finite value |
| set_mask | output | 32 | Mask to OR into the status register |
| clr_mask | output | 32 | Mask of flag bits to clear in the status register |

## Verification
The fraction is tried at exact ties with an odd and with an even low bit. This separates ties-to-even from round-half-up. Guard-clear and sticky-set patterns separate above-half from below-half. An all-ones fraction at exponents 10, 253, 254 and 255 separates the carry-into-exponent path from the saturation path. A denormal with an all-ones fraction shows the carry producing the smallest normal. The same rounding-prone operands are repeated under each directed mode and with inexact enabled, to show that they pass through untouched. Masks are checked in both lanes with an asymmetric flag pattern, so that a wrong shift amount or a wrong lane choice is visible.

// File: rtl/fp_rnd_pkg.sv
package fp_rnd_pkg;

  localparam int STAT_W     = 32;
  localparam int LANE_SHIFT = 15;
  localparam int FLAG_W     = LANE_SHIFT;
  localparam int GUARD_FLAG = 1;
  localparam int INEX_FLAG  = 0;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_POS_INF = 2'b10,
    RND_NEG_INF = 2'b11
  } rnd_mode_e;

  // Move a lower-lane mask into the selected lane.
  function automatic logic [STAT_W-1:0] place_in_lane(input logic [STAT_W-1:0] m,
                                                      input logic upper);
    place_in_lane = upper ? (m << LANE_SHIFT) : m;
  endfunction

  // Nearest-even decision: above half, or exactly half with an odd LSB.
  function automatic logic nearest_even_up(input logic guard, input logic sticky,
                                           input logic lsb);
    nearest_even_up = guard & (sticky | lsb);
  endfunction

endpackage

// File: rtl/fp_denorm_detect.sv
module fp_denorm_detect #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              denorm_o
);
  logic exp_zero;
  logic frac_nonzero;

  assign exp_zero     = (exp_i == '0);
  assign frac_nonzero = |frac_i;
  assign denorm_o     = exp_zero & frac_nonzero;
endmodule

// File: rtl/fp_flag_mask.sv
module fp_flag_mask
  import fp_rnd_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              upper_i,
  output logic [STAT_W-1:0] set_mask_o,
  output logic [STAT_W-1:0] clr_mask_o
);
  logic [STAT_W-1:0] set_low;
  logic [STAT_W-1:0] clr_low;

  // Lower-lane forms, built bit by bit.
  for (genvar b = 0; b < STAT_W; b++) begin : g_bits
    if (b < FLAG_W) begin : g_flag
      assign set_low[b] = flags_i[b];
    end else begin : g_zero
      assign set_low[b] = 1'b0;
    end
    if (b == GUARD_FLAG || b == INEX_FLAG) begin : g_clr
      assign clr_low[b] = 1'b1;
    end else begin : g_keep
      assign clr_low[b] = 1'b0;
    end
  end

  assign set_mask_o = place_in_lane(set_low, upper_i);
  assign clr_mask_o = place_in_lane(clr_low, upper_i);
endmodule

// File: rtl/fp_round_core.sv
module fp_round_core
  import fp_rnd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              guard_i,
  input  logic              sticky_i,
  input  logic [1:0]        mode_i,
  input  logic              inexact_en_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              round_up_o,
  output logic              mant_carry_o,
  output logic              sat_hit_o
);
  localparam logic [EXP_W-1:0] EXP_MAXFIN = {{(EXP_W-1){1'b1}}, 1'b0};
  localparam int               SUM_W      = FRAC_W + 1;

  logic             do_round;
  logic [SUM_W-1:0] frac_sum;

  always_comb begin
    do_round     = !inexact_en_i && (mode_i == RND_NEAREST);
    round_up_o   = do_round && nearest_even_up(guard_i, sticky_i, frac_i[0]);
    frac_sum     = {1'b0, frac_i} + {{FRAC_W{1'b0}}, 1'b1};
    mant_carry_o = round_up_o && frac_sum[SUM_W-1];
    sat_hit_o    = mant_carry_o && (exp_i >= EXP_MAXFIN);

    sign_o = sign_i;
    exp_o  = exp_i;
    frac_o = frac_i;
    if (round_up_o) begin
      if (sat_hit_o) begin
        exp_o  = EXP_MAXFIN;
        frac_o = '1;
      end else if (mant_carry_o) begin
        exp_o  = exp_i + {{(EXP_W-1){1'b0}}, 1'b1};
        frac_o = frac_sum[FRAC_W-1:0];
      end else begin
        frac_o = frac_sum[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fp_sat_rounder.sv
module fp_sat_rounder
  import fp_rnd_pkg::*;
#(
  parameter bit DOUBLE = 1'b0,
  localparam int EXP_W  = DOUBLE ? 11 : 8,
  localparam int FRAC_W = DOUBLE ? 52 : 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic              in_guard,
  input  logic              in_sticky,
  input  logic [1:0]        rnd_mode,
  input  logic              inexact_en,
  input  logic              lane_upper,
  input  logic [14:0]       flag_in,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac,
  output logic              out_denorm,
  output logic              out_rounded,
  output logic              out_sat,
  output logic [31:0]       set_mask,
  output logic [31:0]       clr_mask
);
  // Named internal events, visible to the bound checker.
  logic              rnd_sign_w;
  logic [EXP_W-1:0]  rnd_exp_w;
  logic [FRAC_W-1:0] rnd_frac_w;
  logic              round_up_w;
  logic              mant_carry_w;
  logic              sat_hit_w;
  logic              denorm_w;
  logic [STAT_W-1:0] set_mask_w;
  logic [STAT_W-1:0] clr_mask_w;

  fp_round_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
    .sign_i       (in_sign),
    .exp_i        (in_exp),
    .frac_i       (in_frac),
    .guard_i      (in_guard),
    .sticky_i     (in_sticky),
    .mode_i       (rnd_mode),
    .inexact_en_i (inexact_en),
    .sign_o       (rnd_sign_w),
    .exp_o        (rnd_exp_w),
    .frac_o       (rnd_frac_w),
    .round_up_o   (round_up_w),
    .mant_carry_o (mant_carry_w),
    .sat_hit_o    (sat_hit_w)
  );

  fp_denorm_detect #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_denorm (
    .exp_i    (in_exp),
    .frac_i   (in_frac),
    .denorm_o (denorm_w)
  );

  fp_flag_mask u_mask (
    .flags_i    (flag_in),
    .upper_i    (lane_upper),
    .set_mask_o (set_mask_w),
    .clr_mask_o (clr_mask_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_frac    <= '0;
      out_denorm  <= 1'b0;
      out_rounded <= 1'b0;
      out_sat     <= 1'b0;
      set_mask    <= '0;
      clr_mask    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign    <= rnd_sign_w;
        out_exp     <= rnd_exp_w;
        out_frac    <= rnd_frac_w;
        out_denorm  <= denorm_w;
        out_rounded <= round_up_w;
        out_sat     <= sat_hit_w;
        set_mask    <= set_mask_w;
        clr_mask    <= clr_mask_w;
      end
    end
  end
endmodule

// File: rtl/fp_sat_rounder_chk.sv
module fp_sat_rounder_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [EXP_W-1:0]  in_exp,
  input logic [FRAC_W-1:0] in_frac,
  input logic [1:0]        rnd_mode,
  input logic              inexact_en,
  input logic              round_up_w,
  input logic              mant_carry_w,
  input logic              sat_hit_w,
  input logic              out_valid,
  input logic [EXP_W-1:0]  out_exp,
  input logic [FRAC_W-1:0] out_frac,
  input logic              out_denorm,
  input logic              out_rounded,
  input logic              out_sat,
  input logic [31:0]       clr_mask
);
  localparam logic [EXP_W-1:0] EXP_MAXFIN = {{(EXP_W-1){1'b1}}, 1'b0};

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && inexact_en |=> out_exp == $past(in_exp) && out_frac == $past(in_frac));

  assert_carry_needs_round_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mant_carry_w |-> round_up_w && (&in_frac));

  assert_sat_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sat |-> out_exp == EXP_MAXFIN && (&out_frac));

  assert_sat_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit_w |-> mant_carry_w && in_exp >= EXP_MAXFIN);

  assert_trunc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rnd_mode != 2'b00 |=> out_frac == $past(in_frac) && !out_rounded);

  assert_denorm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_exp != '0 |=> !out_denorm);

  assert_clr_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(clr_mask) == 2);

  assert_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_exp) && $stable(out_frac) && $stable(clr_mask));
endmodule

bind fp_sat_rounder fp_sat_rounder_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_exp       (in_exp),
  .in_frac      (in_frac),
  .rnd_mode     (rnd_mode),
  .inexact_en   (inexact_en),
  .round_up_w   (round_up_w),
  .mant_carry_w (mant_carry_w),
  .sat_hit_w    (sat_hit_w),
  .out_valid    (out_valid),
  .out_exp      (out_exp),
  .out_frac     (out_frac),
  .out_denorm   (out_denorm),
  .out_rounded  (out_rounded),
  .out_sat      (out_sat),
  .clr_mask     (clr_mask)
);

// File: tb/tb_fp_sat_rounder.sv
module tb_fp_sat_rounder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sign, in_guard, in_sticky, inexact_en, lane_upper;
  logic [7:0]  in_exp;
  logic [22:0] in_frac;
  logic [1:0]  rnd_mode;
  logic [14:0] flag_in;
  logic        out_valid, out_sign, out_denorm, out_rounded, out_sat;
  logic [7:0]  out_exp;
  logic [22:0] out_frac;
  logic [31:0] set_mask, clr_mask;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_sat_rounder dut (.*);

  // Layout: esat | mode | inx | sign | exp | frac | g | s | esign | eexp | efrac
  localparam logic [69:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 1'b0, 1'b0, 8'd10,  23'h000001, 1'b1, 1'b0, 1'b0, 8'd10,  23'h000002}, // R2 tie odd
    {1'b0, 2'b00, 1'b0, 1'b0, 8'd10,  23'h000002, 1'b1, 1'b0, 1'b0, 8'd10,  23'h000002}, // R2 tie even
    {1'b0, 2'b00, 1'b0, 1'b1, 8'd10,  23'h000002, 1'b1, 1'b1, 1'b1, 8'd10,  23'h000003}, // R2 above half
    {1'b0, 2'b00, 1'b0, 1'b0, 8'd10,  23'h000003, 1'b0, 1'b1, 1'b0, 8'd10,  23'h000003}, // R2 below half
    {1'b0, 2'b00, 1'b0, 1'b0, 8'd10,  23'h7FFFFF, 1'b1, 1'b1, 1'b0, 8'd11,  23'h000000}, // R3 carry
    {1'b0, 2'b00, 1'b0, 1'b1, 8'd253, 23'h7FFFFF, 1'b1, 1'b0, 1'b1, 8'd254, 23'h000000}, // R3 edge
    {1'b1, 2'b00, 1'b0, 1'b1, 8'd254, 23'h7FFFFF, 1'b1, 1'b0, 1'b1, 8'd254, 23'h7FFFFF}, // R4 sat
    {1'b1, 2'b00, 1'b0, 1'b0, 8'd255, 23'h7FFFFF, 1'b1, 1'b1, 1'b0, 8'd254, 23'h7FFFFF}, // R4 sat
    {1'b0, 2'b00, 1'b0, 1'b0, 8'd0,   23'h7FFFFF, 1'b1, 1'b1, 1'b0, 8'd1,   23'h000000}, // R3 denorm
    {1'b0, 2'b00, 1'b1, 1'b0, 8'd254, 23'h7FFFFF, 1'b1, 1'b1, 1'b0, 8'd254, 23'h7FFFFF}, // R1
    {1'b0, 2'b10, 1'b1, 1'b1, 8'd40,  23'h000005, 1'b1, 1'b1, 1'b1, 8'd40,  23'h000005}, // R1
    {1'b0, 2'b01, 1'b0, 1'b0, 8'd40,  23'h7FFFFF, 1'b1, 1'b1, 1'b0, 8'd40,  23'h7FFFFF}, // R5
    {1'b0, 2'b10, 1'b0, 1'b0, 8'd40,  23'h000005, 1'b1, 1'b1, 1'b0, 8'd40,  23'h000005}, // R5
    {1'b0, 2'b11, 1'b0, 1'b1, 8'd254, 23'h7FFFFF, 1'b1, 1'b1, 1'b1, 8'd254, 23'h7FFFFF}  // R5
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic inx, input logic s,
                       input logic [7:0] e, input logic [22:0] f,
                       input logic g, input logic st);
    @(negedge clk);
    rnd_mode = m; inexact_en = inx; in_sign = s; in_exp = e; in_frac = f;
    in_guard = g; in_sticky = st; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0; in_frac = '0;
    in_guard = 1'b0; in_sticky = 1'b0; rnd_mode = 2'b00; inexact_en = 1'b0;
    lane_upper = 1'b0; flag_in = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset valid", 64'(out_valid), 64'd0);
    check("R9 reset data", {31'd0, out_sign, out_exp, out_frac}, 64'd0);
    check("R9 reset masks", {set_mask, clr_mask}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [69:0] v;
      logic        den;
      v = VEC[i];
      den = (v[64:57] == 8'd0) && (v[56:34] != 23'd0);
      drive(v[68:67], v[66], v[65], v[64:57], v[56:34], v[33], v[32]);
      check($sformatf("R2/R3/R1/R5 vec%0d result", i),
            {31'd0, out_sign, out_exp, out_frac}, {31'd0, v[31:0]});
      check($sformatf("R4 vec%0d sat flag", i), 64'(out_sat), 64'(v[69]));
      check($sformatf("R6 vec%0d denorm", i), 64'(out_denorm), 64'(den));
      check($sformatf("R9 vec%0d valid", i), 64'(out_valid), 64'd1);
    end

    // R5: directed modes never report an increment
    drive(2'b11, 1'b0, 1'b0, 8'd7, 23'h000001, 1'b1, 1'b1);
    check("R5 no increment", 64'(out_rounded), 64'd0);
    // R2: nearest reports the increment
    drive(2'b00, 1'b0, 1'b0, 8'd7, 23'h000001, 1'b1, 1'b0);
    check("R2 increment flag", 64'(out_rounded), 64'd1);

    // R7 / R8: lane masks
    flag_in = 15'h4005; lane_upper = 1'b0;
    drive(2'b00, 1'b0, 1'b0, 8'd3, 23'd0, 1'b0, 1'b0);
    check("R7 lower set", 64'(set_mask), 64'(32'h0000_4005));
    check("R8 lower clr", 64'(clr_mask), 64'(32'h0000_0003));
    lane_upper = 1'b1;
    drive(2'b00, 1'b0, 1'b0, 8'd3, 23'd0, 1'b0, 1'b0);
    check("R7 upper set", 64'(set_mask), 64'(32'h0000_4005) << 15);
    check("R8 upper clr", 64'(clr_mask), 64'(32'h0001_8000));

    // R10: idle inputs leave outputs untouched
    in_exp = 8'd99; in_frac = 23'h123456; lane_upper = 1'b0; flag_in = 15'h7FFF;
    @(negedge clk);
    @(negedge clk);
    check("R10 hold valid", 64'(out_valid), 64'd0);
    check("R10 hold data", {32'd0, out_exp, out_frac}, {32'd0, 8'd3, 23'd0});
    check("R10 hold mask", 64'(set_mask), 64'(32'h0000_4005) << 15);

    // R9: reset again mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 re-reset", {set_mask, out_exp, out_frac, 1'b0}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule